// File: doc/BRIEF.md
# Synchronised Data-and-Valid Output Port

This block is a zero-wait-state AHB-Lite slave. It drives a 16-bit data word and a one-bit valid flag onto a downstream interface. The design ensures that a consumer never sees a new data word paired with an old validity flag, and never sees the reverse.

To publish a value, software takes two steps. First it writes the validity of the coming value into a staging bit at the control location. That bit cannot be read back as a register of its own. Then software writes the data word at the data location. The data write loads the data output and, on the same rising edge, copies the staging bit into the valid output. Reading the control location returns a status word that holds both the valid bit now driven and the staged bit.

The slave decodes only one address bit, so it occupies two word locations, at offsets 0x0 and 0x4. Writes are taken from the registered address phase and use the write data presented in the following data phase.

Top module: `sync_out_port`

## Requirements
- R1: While the asynchronous active-low reset is asserted, the data output, the valid output and the staging bit are all zero. After reset is released, a read of offset 0x4 returns 0.
- R2: A write transfer to offset 0x0 (haddr bit 2 = 0) loads hwdata[15:0] into the data output on the rising edge that ends its data phase. hwdata[31:16] is ignored.
- R3: The same data write copies the staging bit into the valid output on the very edge that loads the data.
- R4: A write to offset 0x4 (haddr bit 2 = 1) sets the staging bit to hwdata[0] and leaves the data and valid outputs unchanged.
- R5: A read of offset 0x0 returns the data output in hrdata[15:0] and zero in hrdata[31:16].
- R6: A read of offset 0x4 returns a status word with bit 0 = current valid, bit 1 = staging bit, and all other bits zero.
- R7: hreadyout is always 1 and hresp is always 0 (OKAY).
- R8: A transfer is accepted only when hsel = 1, hready = 1 and htrans is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01), hsel = 0 or hready = 0 change no state.
- R9: A read that immediately follows a write to the same location, with no idle cycle between them, returns the newly written value.
- R10: The data and valid outputs change only on the edge that ends the data phase of an accepted write to offset 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | ADDR_W (32) | Transfer address; only bit SEL_BIT (2) is decoded |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (not used) |
| hwdata | input | BUS_W (32) | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready; the previous transfer is complete |
| hreadyout | output | 1 | Slave ready, constant 1 |
| hresp | output | 1 | Slave response, constant 0 |
| hrdata | output | BUS_W (32) | Read data, valid in the data phase |
| data_out | output | DATA_W (16) | Published data word |
| data_valid | output | 1 | Validity of data_out |

## Verification
Several properties are checked on every clock cycle. The data and valid outputs stay frozen unless a data write is in its data phase, and such a write loads both the bus data and the staged bit. The staging bit moves only on a control write. Every read returns a word that matches the current register state, and the bus response never stalls or errors. Other behaviour can only be shown by the bench's scenarios. These are the two-step publication sequence seen at the pins, the rejection of IDLE, BUSY, deselected and stalled transfers, a read issued back to back after a write, and an asynchronous reset arriving in the middle of operation.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    reg_sel_e sel;
  } phase_t;

  localparam logic [1:0] TRANS_NONSEQ = 2'b10;

endpackage

// File: rtl/sop_rst_sync.sv
module sop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];

endmodule

// File: rtl/sop_ahb_capture.sv
module sop_ahb_capture
  import sop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [ADDR_W-1:0] haddr,
  output phase_t            ph
);

  phase_t ph_q;
  phase_t ph_d;
  logic   take;
  logic   active;

  // htrans[1] set means NONSEQ or SEQ
  assign active = hsel && htrans[1];
  assign take   = hready;

  always_comb begin
    ph_d = ph_q;
    if (take) begin
      ph_d.wr  = active && hwrite;
      ph_d.rd  = active && !hwrite;
      ph_d.sel = haddr[SEL_BIT] ? SEL_CTRL : SEL_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '{wr: 1'b0, rd: 1'b0, sel: SEL_DATA};
    else        ph_q <= ph_d;
  end

  assign ph = ph_q;

endmodule

// File: rtl/sop_regs.sv
module sop_regs
  import sop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            ph,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stage_in,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              staged_q
);

  logic              ld_data;
  logic              ld_stage;
  logic [DATA_W-1:0] data_d;
  logic              valid_d;
  logic              staged_d;

  assign ld_data  = ph.wr && (ph.sel == SEL_DATA);
  assign ld_stage = ph.wr && (ph.sel == SEL_CTRL);

  always_comb begin
    data_d   = data_q;
    valid_d  = valid_q;
    staged_d = staged_q;
    if (ld_data) begin
      data_d  = wdata;
      valid_d = staged_q;
    end
    if (ld_stage) begin
      staged_d = stage_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      valid_q  <= 1'b0;
      staged_q <= 1'b0;
    end else begin
      data_q   <= data_d;
      valid_q  <= valid_d;
      staged_q <= staged_d;
    end
  end

endmodule

// File: rtl/sop_rdmux.sv
module sop_rdmux
  import sop_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 16
) (
  input  phase_t            ph,
  input  logic [DATA_W-1:0] data_q,
  input  logic              valid_q,
  input  logic              staged_q,
  output logic [BUS_W-1:0]  rdata
);

  localparam int PAD_W = BUS_W - DATA_W;

  logic [BUS_W-1:0] data_word;
  logic [BUS_W-1:0] stat_word;

  assign data_word = {{PAD_W{1'b0}}, data_q};
  assign stat_word = {{(BUS_W-2){1'b0}}, staged_q, valid_q};

  always_comb begin
    rdata = '0;
    if (ph.rd) begin
      rdata = (ph.sel == SEL_CTRL) ? stat_word : data_word;
    end
  end

endmodule

// File: rtl/sync_out_port.sv
module sync_out_port
  import sop_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_W     = 32,
  parameter int DATA_W    = 16,
  parameter int SEL_BIT   = 2,
  parameter int RST_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [BUS_W-1:0]  hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [BUS_W-1:0]  hrdata,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid
);

  logic   rst_q;
  phase_t ph;
  logic   staged_q;
  logic   unused_bits;

  assign unused_bits = ^{hsize, htrans[0], haddr, hwdata[BUS_W-1:DATA_W]};

  sop_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (hclk),
    .arst_n (hresetn),
    .rst_n  (rst_q)
  );

  sop_ahb_capture #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_cap (
    .clk    (hclk),
    .rst_n  (rst_q),
    .hsel   (hsel),
    .hready (hready),
    .htrans (htrans),
    .hwrite (hwrite),
    .haddr  (haddr),
    .ph     (ph)
  );

  sop_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (hclk),
    .rst_n    (rst_q),
    .ph       (ph),
    .wdata    (hwdata[DATA_W-1:0]),
    .stage_in (hwdata[0]),
    .data_q   (data_out),
    .valid_q  (data_valid),
    .staged_q (staged_q)
  );

  sop_rdmux #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_rd (
    .ph       (ph),
    .data_q   (data_out),
    .valid_q  (data_valid),
    .staged_q (staged_q),
    .rdata    (hrdata)
  );

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int ADDR_W  = 32,
  parameter int BUS_W   = 32,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [ADDR_W-1:0] haddr,
  input logic [BUS_W-1:0]  hwdata,
  input logic [BUS_W-1:0]  hrdata,
  input logic              hreadyout,
  input logic              hresp,
  input logic [DATA_W-1:0] data_out,
  input logic              data_valid,
  input logic              staged
);

  logic pend_wd, pend_wc, pend_rd, pend_rc;
  logic go;

  assign go = hready && hsel && (htrans == 2'b10 || htrans == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wd <= 1'b0;
      pend_wc <= 1'b0;
      pend_rd <= 1'b0;
      pend_rc <= 1'b0;
    end else if (hready) begin
      pend_wd <= go && hwrite  && !haddr[SEL_BIT];
      pend_wc <= go && hwrite  &&  haddr[SEL_BIT];
      pend_rd <= go && !hwrite && !haddr[SEL_BIT];
      pend_rc <= go && !hwrite &&  haddr[SEL_BIT];
    end
  end

  p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wd |=> data_out == $past(hwdata[DATA_W-1:0]));

  p_valid_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wd |=> data_valid == $past(staged));

  p_stage_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wc |=> staged == $past(hwdata[0]));

  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wc |=> $stable(staged));

  p_read_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd |-> hrdata == BUS_W'(data_out));

  p_read_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rc |-> (hrdata[BUS_W-1:2] == '0) && (hrdata[0] == data_valid) && (hrdata[1] == staged));

  p_okay_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hreadyout && !hresp);

  p_outputs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wd |=> $stable(data_out) && $stable(data_valid));

endmodule

bind sync_out_port sop_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)
) u_chk (
  .clk        (hclk),
  .rst_n      (rst_q),
  .hsel       (hsel),
  .hready     (hready),
  .htrans     (htrans),
  .hwrite     (hwrite),
  .haddr      (haddr),
  .hwdata     (hwdata),
  .hrdata     (hrdata),
  .hreadyout  (hreadyout),
  .hresp      (hresp),
  .data_out   (data_out),
  .data_valid (data_valid),
  .staged     (staged_q)
);

// File: tb/test_sync_out_port.sv
`timescale 1ns/1ps
module test_sync_out_port;

  logic        hclk = 1'b0;
  logic        hresetn;
  logic        hsel;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [31:0] hwdata;
  logic        hready;
  logic        hreadyout;
  logic        hresp;
  logic [31:0] hrdata;
  logic [15:0] data_out;
  logic        data_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 hclk = ~hclk;

  sync_out_port i_sync_out_port (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .data_out(data_out), .data_valid(data_valid)
  );

  typedef struct packed {
    logic        is_wr;
    logic        off;
    logic [15:0] wdata;
    logic [15:0] e_dout;
    logic        e_vld;
    logic [31:0] e_rd;
  } vec_t;

  // off 0 = data at 0x0, off 1 = control/status at 0x4
  localparam vec_t VECS [10] = '{
    '{1'b1, 1'b1, 16'h0001, 16'h0000, 1'b0, 32'h0},         // stage 1 (R4)
    '{1'b0, 1'b1, 16'h0000, 16'h0000, 1'b0, 32'h2},         // status (R6)
    '{1'b1, 1'b0, 16'h1234, 16'h1234, 1'b1, 32'h0},         // data (R2 R3)
    '{1'b0, 1'b1, 16'h0000, 16'h1234, 1'b1, 32'h3},         // status (R6)
    '{1'b1, 1'b1, 16'h0000, 16'h1234, 1'b1, 32'h0},         // stage 0 (R4)
    '{1'b0, 1'b0, 16'h0000, 16'h1234, 1'b1, 32'h0000_1234}, // data read (R5)
    '{1'b1, 1'b0, 16'hBEEF, 16'hBEEF, 1'b0, 32'h0},         // data (R2 R3)
    '{1'b0, 1'b1, 16'h0000, 16'hBEEF, 1'b0, 32'h0},         // status (R6)
    '{1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 32'h0},         // all ones (R2)
    '{1'b0, 1'b0, 16'h0000, 16'hFFFF, 1'b0, 32'h0000_FFFF}  // upper zero (R5)
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; haddr = '0; hready = 1'b1;
  endtask

  // returns in the data phase (before the register edge)
  task automatic wr(input logic off, input logic [15:0] d);
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = off ? 32'h4 : 32'h0;
    @(negedge hclk);
    idle();
    hwdata = {16'hA5A5, d};
  endtask

  task automatic rd(input logic off, output logic [31:0] v);
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b0; haddr = off ? 32'h4 : 32'h0;
    @(negedge hclk);
    idle();
    v = hrdata;
  endtask

  // a transfer that must be ignored, data phase carries data write
  task automatic bad_wr(input logic s, input logic [1:0] t, input logic rdy);
    @(negedge hclk);
    hsel = s; htrans = t; hwrite = 1'b1; haddr = 32'h0; hready = rdy;
    @(negedge hclk);
    idle();
    hwdata = 32'h0000_0000;
    @(negedge hclk);
  endtask

  initial begin
    repeat (100000) @(posedge hclk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle();
    hsize = 3'b010; hwdata = '0;
    hresetn = 1'b0;
    repeat (3) @(negedge hclk);
    chk(data_out == 16'h0 && !data_valid, "R1 reset outputs", {15'b0, data_valid, data_out}, 32'h0);
    hresetn = 1'b1;
    repeat (3) @(negedge hclk);
    rd(1'b1, v);
    chk(v == 32'h0, "R1 status after reset", v, 32'h0);

    for (int i = 0; i < 10; i++) begin
      if (VECS[i].is_wr) begin
        wr(VECS[i].off, VECS[i].wdata);
        @(negedge hclk);
      end else begin
        rd(VECS[i].off, v);
        chk(v == VECS[i].e_rd, VECS[i].off ? "R6 status read" : "R5 data read", v, VECS[i].e_rd);
        @(negedge hclk);
      end
      chk(data_out == VECS[i].e_dout, "R2 data_out", {16'b0, data_out}, {16'b0, VECS[i].e_dout});
      chk(data_valid == VECS[i].e_vld, "R3 data_valid", {31'b0, data_valid}, {31'b0, VECS[i].e_vld});
      chk(hreadyout && !hresp, "R7 ready/okay", {30'b0, hreadyout, hresp}, 32'h2);
    end

    // R8: rejected transfers
    bad_wr(1'b0, 2'b10, 1'b1);
    chk(data_out == 16'hFFFF, "R8 hsel low", {16'b0, data_out}, 32'hFFFF);
    bad_wr(1'b1, 2'b00, 1'b1);
    chk(data_out == 16'hFFFF, "R8 idle", {16'b0, data_out}, 32'hFFFF);
    bad_wr(1'b1, 2'b01, 1'b1);
    chk(data_out == 16'hFFFF, "R8 busy", {16'b0, data_out}, 32'hFFFF);
    bad_wr(1'b1, 2'b10, 1'b0);
    chk(data_out == 16'hFFFF, "R8 hready low", {16'b0, data_out}, 32'hFFFF);
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h4;
    @(negedge hclk);
    idle(); hwdata = 32'h1;
    rd(1'b1, v);
    chk(v == 32'h0, "R8 deselected stage write", v, 32'h0);

    // R3/R10: both outputs change together on one edge
    wr(1'b1, 16'h0001);
    wr(1'b0, 16'h5555);
    chk(data_out == 16'hFFFF && !data_valid, "R10 old pair in data phase",
        {15'b0, data_valid, data_out}, 32'h0000_FFFF);
    @(negedge hclk);
    chk(data_out == 16'h5555 && data_valid, "R3 new pair same edge",
        {15'b0, data_valid, data_out}, 32'h0001_5555);

    // R9: write then read back to back
    @(negedge hclk);
    hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = 32'h0;
    @(negedge hclk);
    hwdata = 32'h0000_0F0F; hwrite = 1'b0; htrans = 2'b10;
    @(negedge hclk);
    idle();
    chk(hrdata == 32'h0000_0F0F, "R9 back-to-back read", hrdata, 32'h0000_0F0F);

    // R1: reset in the middle of operation
    @(negedge hclk);
    hresetn = 1'b0;
    #1;
    chk(data_out == 16'h0 && !data_valid, "R1 async clear", {15'b0, data_valid, data_out}, 32'h0);
    @(negedge hclk);
    hresetn = 1'b1;
    repeat (3) @(negedge hclk);
    rd(1'b1, v);
    chk(v == 32'h0, "R1 status cleared", v, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule